// File: doc/BRIEF.md
# Pipeline CPI Penalty Monitor

This block watches the retire end of a five-stage pipeline and keeps the numbers needed to work out cycles per instruction. Every enabled cycle it counts one clock and, from two per-cycle flags, whether an instruction or a bubble left the pipeline. It also counts hazard events by cause: load/use stalls, mispredicted branches and returns. It keeps a "charged" bubble total in which each load/use event weighs one bubble, each mispredict two and each return three. Software turns these into CPI as one plus bubbles over instructions.

All counters saturate at their maximum value instead of wrapping, and a sticky overflow flag records that an increment was lost. A synchronous clear zeroes every counter and the flag together, and counting is gated by an enable. A combinational mismatch output checks two invariants: cycles equal instructions plus bubbles, and charged bubbles equal observed bubbles. The mismatch output is only meaningful once the pipeline has drained, because a hazard event is charged when it is detected, and its bubbles retire later. An on-demand restoring divider gives observed bubbles per instruction in unsigned Q8.8 after a fixed latency.

Top module: `perf_penalty_mon`

## Requirements
- R1: After reset every counter reads zero, and `ovf_o`, `mismatch_o`, `div_busy_o`, `div_done_o` and `ratio_o` are all zero.
- R2: On each edge with `en_i` high and `clr_i` low, the cycle counter adds 1. The instruction counter adds 1 if `retire_ins_i` is high, and the bubble counter adds 1 if `retire_bub_i` is high. With `en_i` low no counter changes.
- R3: A counter whose increment would pass 2^CNT_W-1 stays at 2^CNT_W-1, and `ovf_o` is set. `ovf_o` stays high until a clear or a reset.
- R4: `clr_i` high on an edge zeroes all counters and `ovf_o`, whatever the other inputs are on that edge.
- R5: The load/use, mispredict and return event counters each add 1 per enabled edge on which `ev_load_i`, `ev_misp_i` or `ev_ret_i` is high.
- R6: The charged-bubble counter adds 1 for a load/use event, 2 for a mispredict and 3 for a return. When several events come on the same edge, their weights are summed.
- R7: `mismatch_o` is high exactly when the cycle count differs from instructions plus bubbles, or when the charged-bubble count differs from the bubble count.
- R8: `rd_data_o` shows the counter picked by `rd_sel_i`, combinationally: 0 cycles, 1 instructions, 2 bubbles, 3 load/use events, 4 mispredicts, 5 returns, 6 charged bubbles, 7 reads zero.
- R9: `div_start_i` high while `div_busy_o` is low captures the bubble and instruction counts and raises `div_busy_o`. Exactly CNT_W+8 edges later `div_done_o` rises, and `ratio_o` then holds floor(bubbles*256/instructions), saturated to 0xFFFF. A zero instruction count gives 0xFFFF. A start while busy is ignored.
- R10: `div_done_o` and `ratio_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Counting enable |
| clr_i | input | 1 | Synchronous clear of all counters and overflow |
| retire_ins_i | input | 1 | An instruction retired this cycle |
| retire_bub_i | input | 1 | A bubble retired this cycle |
| ev_load_i | input | 1 | Load/use hazard event pulse |
| ev_misp_i | input | 1 | Mispredicted branch event pulse |
| ev_ret_i | input | 1 | Return event pulse |
| rd_sel_i | input | 3 | Counter select for reading |
| rd_data_o | output | CNT_W | Selected counter value |
| ovf_o | output | 1 | Sticky saturation flag |
| mismatch_o | output | 1 | Invariant violation |
| div_start_i | input | 1 | Start a ratio division |
| div_busy_o | output | 1 | Division in progress |
| div_done_o | output | 1 | Ratio valid |
| ratio_o | output | RATIO_W | Bubbles per instruction, Q8.8 |

## Verification
The assertions check, on every cycle, the local counting rules. They cover the cycle step, holding while disabled, a clear winning over counting, saturation holding at the top value, the sticky overflow flag, the weight-3 charge of a return, the fixed divider latency (checked with a counter), and done holding its value. Only the bench scenarios can show the values themselves. These are the read-select encoding, the weighted sums when events coincide, whether the mismatch output agrees with balanced or unbalanced traffic, and the correct Q8.8 quotients, including the divide-by-zero case and the start that is ignored while the divider is busy.

// File: rtl/perf_pkg.sv
`timescale 1ns/1ps
package perf_pkg;
  typedef enum logic [2:0] {
    SEL_CYC  = 3'd0,
    SEL_INS  = 3'd1,
    SEL_BUB  = 3'd2,
    SEL_LD   = 3'd3,
    SEL_MISP = 3'd4,
    SEL_RET  = 3'd5,
    SEL_CHG  = 3'd6,
    SEL_NONE = 3'd7
  } rd_sel_e;

  localparam int NUM_CTR = 7;
  localparam int INC_W   = 3;
endpackage

// File: rtl/perf_sat_ctr.sv
`timescale 1ns/1ps
module perf_sat_ctr #(
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o,
  output logic          lost_o
);
  logic [W:0]   sum;
  logic [W-1:0] cnt_q, cnt_d;
  logic         upd;

  always_comb begin
    sum    = {1'b0, cnt_q} + (W+1)'(inc_i);
    lost_o = sum[W];
    upd    = clr_i | (inc_i != '0);
    if (clr_i)       cnt_d = '0;
    else if (sum[W]) cnt_d = '1;
    else             cnt_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_q_div.sv
`timescale 1ns/1ps
module perf_q_div #(
  parameter int NW   = 32,
  parameter int FRAC = 8,
  parameter int QW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [NW-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int DW = NW + FRAC;
  localparam int CW = $clog2(DW + 1);

  logic [NW-1:0] rem_q, rem_d, den_q, den_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done_q, done_d;
  logic [NW:0]   shifted;
  logic [NW+1:0] diff;
  logic          take, accept, upd;

  always_comb begin
    accept  = start_i & ~busy_q;
    shifted = {rem_q, quo_q[DW-1]};
    diff    = {1'b0, shifted} - {2'b00, den_q};
    take    = ~diff[NW+1];
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = done_q;
    if (accept) begin
      rem_d  = '0;
      quo_d  = {num_i, {FRAC{1'b0}}};
      den_d  = den_i;
      cnt_d  = CW'(DW);
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (busy_q) begin
      rem_d = take ? NW'(diff) : NW'(shifted);
      quo_d = {quo_q[DW-2:0], take};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
    upd = accept | busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (upd) begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  generate
    if (DW > QW) begin : g_sat
      assign quo_o = (|quo_q[DW-1:QW]) ? '1 : quo_q[QW-1:0];
    end else begin : g_ext
      assign quo_o = QW'(quo_q);
    end
  endgenerate

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/perf_penalty_mon.sv
`timescale 1ns/1ps
module perf_penalty_mon
  import perf_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int FRAC_W  = 8,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               retire_ins_i,
  input  logic               retire_bub_i,
  input  logic               ev_load_i,
  input  logic               ev_misp_i,
  input  logic               ev_ret_i,
  input  logic [2:0]         rd_sel_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               ovf_o,
  output logic               mismatch_o,
  input  logic               div_start_i,
  output logic               div_busy_o,
  output logic               div_done_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [INC_W-1:0] inc [NUM_CTR];
  logic [CNT_W-1:0] cnt [NUM_CTR];
  logic [NUM_CTR-1:0] lost;
  logic [INC_W-1:0] charge;
  logic ovf_q, ovf_d;
  logic [CNT_W-1:0] cyc_cnt, ins_cnt, bub_cnt, chg_cnt;
  logic [CNT_W:0]   ins_bub_sum;

  always_comb begin
    charge = {2'b00, ev_load_i} + {1'b0, ev_misp_i, 1'b0} + {1'b0, ev_ret_i, ev_ret_i};
    inc[SEL_CYC]  = en_i ? INC_W'(1) : '0;
    inc[SEL_INS]  = en_i ? INC_W'(retire_ins_i) : '0;
    inc[SEL_BUB]  = en_i ? INC_W'(retire_bub_i) : '0;
    inc[SEL_LD]   = en_i ? INC_W'(ev_load_i) : '0;
    inc[SEL_MISP] = en_i ? INC_W'(ev_misp_i) : '0;
    inc[SEL_RET]  = en_i ? INC_W'(ev_ret_i) : '0;
    inc[SEL_CHG]  = en_i ? charge : '0;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CTR; g++) begin : g_ctr
      perf_sat_ctr #(.W(CNT_W), .IW(INC_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .inc_i  (inc[g]),
        .cnt_o  (cnt[g]),
        .lost_o (lost[g])
      );
    end
  endgenerate

  assign cyc_cnt = cnt[SEL_CYC];
  assign ins_cnt = cnt[SEL_INS];
  assign bub_cnt = cnt[SEL_BUB];
  assign chg_cnt = cnt[SEL_CHG];

  always_comb ovf_d = clr_i ? 1'b0 : (ovf_q | (|lost));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
  assign ovf_o = ovf_q;

  always_comb begin
    ins_bub_sum = {1'b0, ins_cnt} + {1'b0, bub_cnt};
    mismatch_o  = ({1'b0, cyc_cnt} != ins_bub_sum) || (chg_cnt != bub_cnt);
  end

  always_comb begin
    case (rd_sel_e'(rd_sel_i))
      SEL_CYC:  rd_data_o = cnt[SEL_CYC];
      SEL_INS:  rd_data_o = cnt[SEL_INS];
      SEL_BUB:  rd_data_o = cnt[SEL_BUB];
      SEL_LD:   rd_data_o = cnt[SEL_LD];
      SEL_MISP: rd_data_o = cnt[SEL_MISP];
      SEL_RET:  rd_data_o = cnt[SEL_RET];
      SEL_CHG:  rd_data_o = cnt[SEL_CHG];
      default:  rd_data_o = '0;
    endcase
  end

  perf_q_div #(.NW(CNT_W), .FRAC(FRAC_W), .QW(RATIO_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start_i),
    .num_i   (bub_cnt),
    .den_i   (ins_cnt),
    .busy_o  (div_busy_o),
    .done_o  (div_done_o),
    .quo_o   (ratio_o)
  );
endmodule

// File: rtl/perf_penalty_mon_chk.sv
`timescale 1ns/1ps
module perf_penalty_mon_chk #(
  parameter int CNT_W   = 32,
  parameter int DIV_W   = 40,
  parameter int RATIO_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic               clr_i,
  input logic               ev_load_i,
  input logic               ev_misp_i,
  input logic               ev_ret_i,
  input logic               div_start_i,
  input logic               div_busy_o,
  input logic               div_done_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               ovf_o,
  input logic [CNT_W-1:0]   cyc,
  input logic [CNT_W-1:0]   ins,
  input logic [CNT_W-1:0]   bub,
  input logic [CNT_W-1:0]   chg
);
  localparam int CW = $clog2(DIV_W + 1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       win_q <= '0;
    else if (div_start_i && !div_busy_o) win_q <= CW'(DIV_W);
    else if (win_q != '0)             win_q <= win_q - 1'b1;
  end

  a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && cyc != '1) |=> cyc == $past(cyc) + 1'b1);

  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(cyc) && $stable(ins) && $stable(bub) && $stable(chg)));

  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == '1 && !clr_i) |=> cyc == '1);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cyc == '0 && ins == '0 && bub == '0 && chg == '0 && !ovf_o));

  a_r6_ret_charge: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && ev_ret_i && !ev_load_i && !ev_misp_i && chg < {CNT_W{1'b1}} - 3)
    |=> chg == $past(chg) + 3);

  a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_done_o) |-> (win_q == '0 && $past(win_q) == CW'(1)));

  a_r9_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy_o |-> !div_done_o);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done_o && !(div_start_i && !div_busy_o)) |=> (div_done_o && $stable(ratio_o)));
endmodule

bind perf_penalty_mon perf_penalty_mon_chk #(
  .CNT_W(CNT_W), .DIV_W(CNT_W + FRAC_W), .RATIO_W(RATIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i),
  .ev_load_i(ev_load_i), .ev_misp_i(ev_misp_i), .ev_ret_i(ev_ret_i),
  .div_start_i(div_start_i), .div_busy_o(div_busy_o), .div_done_o(div_done_o),
  .ratio_o(ratio_o), .ovf_o(ovf_o),
  .cyc(cyc_cnt), .ins(ins_cnt), .bub(bub_cnt), .chg(chg_cnt)
);

// File: tb/test_perf_penalty_mon.sv
`timescale 1ns/1ps
module test_perf_penalty_mon;
  localparam int CW   = 8;
  localparam int RW   = 16;
  localparam int MAXV = (1 << CW) - 1;
  localparam int LAT  = CW + 8;

  // vector bits: {en, ins, bub, ld, misp, ret}
  localparam logic [5:0] VEC [12] = '{
    6'b110000, 6'b110100, 6'b101000, 6'b110010, 6'b101000, 6'b101000,
    6'b011111, 6'b110001, 6'b101000, 6'b101110, 6'b110000, 6'b101000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic en, clr, rins, rbub, eld, emisp, eret, dstart;
  logic [2:0] sel;
  logic [CW-1:0] rd;
  logic ovf, mism, busy, done;
  logic [RW-1:0] ratio;

  int checks = 0, errors = 0;
  int m [7];
  int movf;
  bit finished = 0;

  always #2.5 clk = ~clk;

  perf_penalty_mon #(.CNT_W(CW), .FRAC_W(8), .RATIO_W(RW)) i_perf_penalty_mon (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clr_i(clr),
    .retire_ins_i(rins), .retire_bub_i(rbub),
    .ev_load_i(eld), .ev_misp_i(emisp), .ev_ret_i(eret),
    .rd_sel_i(sel), .rd_data_o(rd), .ovf_o(ovf), .mismatch_o(mism),
    .div_start_i(dstart), .div_busy_o(busy), .div_done_o(done), .ratio_o(ratio)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic bump(input int k, input int amt);
    if (m[k] + amt > MAXV) begin m[k] = MAXV; movf = 1; end
    else m[k] = m[k] + amt;
  endtask

  task automatic model_step(input bit e, input bit i, input bit b,
                            input bit l, input bit p, input bit r);
    if (e) begin
      bump(0, 1); bump(1, i); bump(2, b);
      bump(3, l); bump(4, p); bump(5, r);
      bump(6, l + 2 * p + 3 * r);
    end
  endtask

  task automatic model_clear;
    for (int k = 0; k < 7; k++) m[k] = 0;
    movf = 0;
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      #0.1;
      check($sformatf("R8 %s sel%0d", tag, s), int'(rd), (s < 7) ? m[s] : 0);
    end
    check({"R3 ovf ", tag}, int'(ovf), movf);
    check({"R7 mismatch ", tag}, int'(mism),
          ((m[0] != m[1] + m[2]) || (m[6] != m[2])) ? 1 : 0);
  endtask

  task automatic idle_inputs;
    en = 0; clr = 0; rins = 0; rbub = 0; eld = 0; emisp = 0; eret = 0; dstart = 0;
  endtask

  task automatic do_clear;
    idle_inputs(); clr = 1; tick(); clr = 0; model_clear();
  endtask

  task automatic load_counts(input int ni, input int nb);
    en = 1; rins = 1; rbub = 0;
    for (int k = 0; k < ni; k++) begin tick(); model_step(1, 1, 0, 0, 0, 0); end
    rins = 0; rbub = 1;
    for (int k = 0; k < nb; k++) begin tick(); model_step(1, 0, 1, 0, 0, 0); end
    idle_inputs();
  endtask

  task automatic run_div(input string tag, input int exp_ratio, input bit retry);
    int n;
    dstart = 1; tick(); dstart = 0;
    check({"R9 busy after start ", tag}, int'(busy), 1);
    check({"R9 done low ", tag}, int'(done), 0);
    n = 0;
    while (!done && n < 100) begin
      dstart = (retry && n == 3);
      tick(); n++;
    end
    dstart = 0;
    check({"R9 latency ", tag}, n, LAT);
    check({"R9 ratio ", tag}, int'(ratio), exp_ratio);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs(); sel = 0; rst_n = 0; model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    check_all("R1 reset");
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ratio", int'(ratio), 0);

    // R2 R5 R6 R7 vector walk
    for (int v = 0; v < 12; v++) begin
      {en, rins, rbub, eld, emisp, eret} = VEC[v];
      tick();
      model_step(VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
      idle_inputs();
      check_all($sformatf("vec%0d", v));
    end

    // R4 clear wins over counting
    en = 1; rins = 1; eret = 1; clr = 1;
    tick(); idle_inputs(); model_clear();
    check_all("R4 clear");

    // R3 saturation and sticky overflow
    en = 1; rins = 1; eret = 1;
    for (int k = 0; k < 300; k++) begin tick(); model_step(1, 1, 0, 0, 0, 1); end
    idle_inputs();
    check_all("R3 saturated");
    check("R3 cycles at max", m[0], MAXV);
    repeat (4) tick();
    check("R3 ovf stays", int'(ovf), 1);
    do_clear();
    check_all("R4 after sat");

    // R9 divider: 3 bubbles / 5 instructions = 153 in Q8.8, restart ignored
    load_counts(5, 3);
    check_all("R9 setup");
    run_div("3/5", 153, 1'b1);
    // R10 hold
    repeat (3) tick();
    check("R10 done hold", int'(done), 1);
    check("R10 ratio hold", int'(ratio), 153);

    // R9 1 bubble / 4 instructions = 64
    do_clear();
    load_counts(4, 1);
    run_div("1/4", 64, 1'b0);

    // R9 zero instructions saturates
    do_clear();
    load_counts(0, 2);
    run_div("2/0", 16'hFFFF, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule